// File: doc/BRIEF.md
# Bit-Serial Associative Tag Array

The block is a small content-addressable processing array. It holds WORDS stored words of BITS bits each. Every word carries two result tags, called A and B, and a participation mask bit. A single command port loads words and their mask bits and loads a search pattern of FIELD bits. It also starts two kinds of operation that act on every word in the same cycle.

A windowed compare walks through FIELD consecutive bit columns, one column per clock. Each participating word has its A tag cleared to a match-so-far value of 1 at the start. At every step the tag is ANDed with the equality of that word's bit and the matching pattern bit. A column-OR takes one stored bit column, ORs it with the A tags, and writes the result into the B tags in a single cycle.

The two tag vectors are always visible on the readout outputs. A host can therefore chain a search with a combining step and read the word-wise results in parallel.

Top module: `assoc_array`

## Requirements
- R1: During and after reset, tag_a and tag_b are all zero, busy, done and err are low, every mask bit is 1 (all words take part) and the pattern is zero.
- R2: A command is taken on a rising edge with cmd_valid high and busy low. cmd_op encodes 0 = write word, 1 = load pattern, 2 = windowed compare, 3 = column-OR. A write stores cmd_data into word cmd_addr, where data bit k is column k, and stores cmd_mask as that word's mask bit. A pattern load keeps cmd_data[FIELD-1:0].
- R3: An accepted compare raises busy for exactly FIELD cycles. When busy falls, done is high for one cycle.
- R4: After a compare at column c, the A tag of each participating word is 1 exactly when its bit c+i equals pattern bit i for every i in 0..FIELD-1. Otherwise the A tag is 0.
- R5: A column-OR at column c sets the B tag of each participating word to its bit c ORed with its A tag. This happens on the accepting edge and is followed by a one-cycle done pulse, with busy staying low.
- R6: A word whose mask bit is 0 keeps its A and B tags unchanged through compares and column-ORs.
- R7: A compare with c+FIELD > BITS, or a column-OR with c >= BITS, gives a one-cycle err pulse. It leaves every tag unchanged and does not raise busy or done.
- R8: Any command presented while busy is high is ignored: it changes neither the stored words, the masks nor the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Command code |
| cmd_addr | input | $clog2(WORDS) | Word index for writes |
| cmd_col | input | $clog2(BITS) | Starting or selected bit column |
| cmd_data | input | BITS | Word data, or pattern in the low FIELD bits |
| cmd_mask | input | 1 | Mask bit stored with a write |
| busy | output | 1 | Compare in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal column pulse |
| tag_a | output | WORDS | A tag vector, bit w for word w |
| tag_b | output | WORDS | B tag vector, bit w for word w |

## Verification
The checks take for granted that reset is held for at least one clock before the first command. They also assume that a word's mask bit can change only through an accepted write, so the mask sampled one cycle earlier decides whether that word's tags may move. The stimulus holds reset for several cycles and issues most commands only while the array is idle. It deliberately issues a pattern load and a word write during a running compare. Follow-up compares then show, through the tags, that the old pattern and the old word contents were kept.

// File: rtl/assoc_array.sv
module assoc_array #(
  parameter int WORDS = 8,
  parameter int BITS  = 16,
  parameter int FIELD = 4,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CW = (BITS > 1) ? $clog2(BITS) : 1,
  localparam int FW = (FIELD > 1) ? $clog2(FIELD) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [CW-1:0]    cmd_col,
  input  logic [BITS-1:0]  cmd_data,
  input  logic             cmd_mask,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [WORDS-1:0] tag_a,
  output logic [WORDS-1:0] tag_b
);

  typedef enum logic [1:0] {OP_WRITE = 2'd0, OP_PAT = 2'd1, OP_CMP = 2'd2, OP_OR = 2'd3} op_e;

  logic [BITS-1:0]  mem [WORDS];
  logic [WORDS-1:0] mask_q, a_q, b_q;
  logic [FIELD-1:0] pat_q;
  logic [CW-1:0]    col_q;
  logic [FW-1:0]    step_q;
  logic             busy_q, done_q, err_q;

  wire [CW-1:0] cur_col = col_q + CW'(step_q);
  wire          win_ok  = (int'(cmd_col) + FIELD) <= BITS;
  wire          col_ok  = int'(cmd_col) < BITS;
  wire          last    = int'(step_q) == FIELD - 1;
  wire          pbit    = pat_q[step_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      mask_q <= '1;
      a_q    <= '0;
      b_q    <= '0;
      pat_q  <= '0;
      col_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (busy_q) begin
        for (int w = 0; w < WORDS; w++)
          if (mask_q[w]) a_q[w] <= a_q[w] & (mem[w][cur_col] == pbit);
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end else if (cmd_valid) begin
        case (op_e'(cmd_op))
          OP_WRITE: if (int'(cmd_addr) < WORDS) begin
            mem[cmd_addr]    <= cmd_data;
            mask_q[cmd_addr] <= cmd_mask;
          end
          OP_PAT: pat_q <= cmd_data[FIELD-1:0];
          OP_CMP: if (win_ok) begin
            col_q  <= cmd_col;
            step_q <= '0;
            busy_q <= 1'b1;
            for (int w = 0; w < WORDS; w++)
              if (mask_q[w]) a_q[w] <= 1'b1;
          end else begin
            err_q <= 1'b1;
          end
          OP_OR: if (col_ok) begin
            for (int w = 0; w < WORDS; w++)
              if (mask_q[w]) b_q[w] <= mem[w][cmd_col] | a_q[w];
            done_q <= 1'b1;
          end else begin
            err_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign err   = err_q;
  assign tag_a = a_q;
  assign tag_b = b_q;

endmodule

// File: rtl/assoc_array_chk.sv
module assoc_array_chk #(
  parameter int WORDS = 8,
  parameter int FIELD = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [WORDS-1:0] tag_a,
  input logic [WORDS-1:0] tag_b,
  input logic [WORDS-1:0] mask
);

  logic [7:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst) busy_cnt <= '0;
    else     busy_cnt <= busy ? busy_cnt + 8'd1 : 8'd0;
  end

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (rst) busy |-> int'(busy_cnt) < FIELD);

  // R3
  done_on_fall_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> ($stable(tag_a) && $stable(tag_b) && !busy && !done));

  // R5
  or_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(busy)) |-> $stable(tag_a));

  for (genvar w = 0; w < WORDS; w++) begin : g_w
    // R6
    masked_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(mask[w]) |-> ($stable(tag_a[w]) && $stable(tag_b[w])));
  end

endmodule

bind assoc_array assoc_array_chk #(.WORDS(WORDS), .FIELD(FIELD)) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .err(err),
  .tag_a(tag_a), .tag_b(tag_b), .mask(mask_q)
);

// File: tb/assoc_array_tb_top.sv
module assoc_array_tb_top;
  localparam int WORDS = 8;
  localparam int BITS  = 16;
  localparam int FIELD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [2:0] cmd_addr = '0;
  logic [3:0] cmd_col = '0;
  logic [BITS-1:0] cmd_data = '0;
  logic cmd_mask = 1'b0;
  logic busy, done, err;
  logic [WORDS-1:0] tag_a, tag_b;

  always #10 clk = ~clk;

  assoc_array #(.WORDS(WORDS), .BITS(BITS), .FIELD(FIELD)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_col(cmd_col), .cmd_data(cmd_data),
    .cmd_mask(cmd_mask), .busy(busy), .done(done), .err(err),
    .tag_a(tag_a), .tag_b(tag_b));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [BITS-1:0]  m_mem [WORDS];
  logic [WORDS-1:0] m_mask = '1, m_a = '0, m_b = '0;
  logic [FIELD-1:0] m_pat = '0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [2:0] addr, logic [3:0] col,
                       logic [BITS-1:0] data, logic mbit);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
    cmd_col = col; cmd_data = data; cmd_mask = mbit;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wr(int addr, logic [BITS-1:0] data, logic mbit);
    issue(2'd0, 3'(addr), 4'd0, data, mbit);
    m_mem[addr] = data;
    m_mask[addr] = mbit;
  endtask

  task automatic ld_pat(logic [FIELD-1:0] p);
    issue(2'd1, 3'd0, 4'd0, {{(BITS-FIELD){1'b1}}, p}, 1'b0);
    m_pat = p;
  endtask

  task automatic model_cmp(int col);
    for (int w = 0; w < WORDS; w++)
      if (m_mask[w]) m_a[w] = (m_mem[w][col +: FIELD] == m_pat);
  endtask

  task automatic wait_done(string req);
    int cnt = 0;
    check({req, " R3 busy after accept"}, 32'(busy), 32'd1);
    while (!done && cnt < 20) begin
      @(negedge clk);
      cnt++;
    end
    check({req, " R3 busy length"}, 32'(cnt), 32'(FIELD));
    check({req, " R3 busy low at done"}, 32'(busy), 32'd0);
    @(negedge clk);
    check({req, " R3 done is one cycle"}, 32'(done), 32'd0);
  endtask

  task automatic run_cmp(int col, string req);
    issue(2'd2, 3'd0, 4'(col), '0, 1'b0);
    wait_done(req);
    model_cmp(col);
    check({req, " tag_a"}, 32'(tag_a), 32'(m_a));
    check({req, " tag_b"}, 32'(tag_b), 32'(m_b));
  endtask

  task automatic run_or(int col, string req);
    issue(2'd3, 3'd0, 4'(col), '0, 1'b0);
    for (int w = 0; w < WORDS; w++)
      if (m_mask[w]) m_b[w] = m_mem[w][col] | m_a[w];
    check({req, " R5 done pulse"}, 32'(done), 32'd1);
    check({req, " R5 no busy"}, 32'(busy), 32'd0);
    check({req, " tag_b"}, 32'(tag_b), 32'(m_b));
    check({req, " tag_a"}, 32'(tag_a), 32'(m_a));
  endtask

  task automatic t_reset();
    check("R1 tag_a", 32'(tag_a), 32'd0);
    check("R1 tag_b", 32'(tag_b), 32'd0);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 err", 32'(err), 32'd0);
  endtask

  task automatic t_load_and_compare();
    for (int w = 0; w < WORDS; w++) m_mem[w] = '0;
    run_cmp(0, "R1 zero pattern matches all words");
    wr(0, 16'hA5C3, 1'b1);
    wr(1, 16'h1233, 1'b1);
    wr(2, 16'h3C5A, 1'b1);
    wr(3, 16'hFFF3, 1'b1);
    wr(4, 16'h0000, 1'b1);
    wr(5, 16'h5A53, 1'b1);
    wr(6, 16'hC3A5, 1'b1);
    wr(7, 16'h3003, 1'b1);
    ld_pat(4'h3);
    run_cmp(0, "R2 R4 low window");
    ld_pat(4'hA);
    run_cmp(4, "R4 middle window");
    ld_pat(4'h3);
    run_cmp(12, "R4 top legal window");
    ld_pat(4'h5);
    run_cmp(5, "R4 unaligned window");
  endtask

  task automatic t_or();
    ld_pat(4'h3);
    run_cmp(0, "R4 setup for OR");
    run_or(15, "R5 column 15");
    run_or(2, "R5 column 2");
  endtask

  task automatic t_mask();
    wr(3, 16'hFFF3, 1'b0);
    wr(5, 16'h5A53, 1'b0);
    ld_pat(4'hC);
    run_cmp(4, "R6 masked compare");
    run_or(1, "R6 masked OR");
    wr(3, 16'hFFF3, 1'b1);
    wr(5, 16'h5A53, 1'b1);
  endtask

  task automatic t_error();
    logic [WORDS-1:0] a0, b0;
    a0 = tag_a; b0 = tag_b;
    issue(2'd2, 3'd0, 4'd13, '0, 1'b0);
    check("R7 err pulse", 32'(err), 32'd1);
    check("R7 no busy", 32'(busy), 32'd0);
    check("R7 no done", 32'(done), 32'd0);
    check("R7 tag_a kept", 32'(tag_a), 32'(a0));
    check("R7 tag_b kept", 32'(tag_b), 32'(b0));
    @(negedge clk);
    check("R7 err one cycle", 32'(err), 32'd0);
  endtask

  task automatic t_busy_ignore();
    ld_pat(4'h3);
    issue(2'd2, 3'd0, 4'd0, '0, 1'b0);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_data = 16'h000F;
    @(negedge clk);
    cmd_op = 2'd0; cmd_addr = 3'd4; cmd_data = 16'hFFFF; cmd_mask = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    model_cmp(0);
    check("R8 pattern load ignored", 32'(tag_a), 32'(m_a));
    @(negedge clk);
    ld_pat(4'h0);
    run_cmp(8, "R8 word write ignored");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load_and_compare();
    t_or();
    t_mask();
    t_error();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule